// File: doc/BRIEF.md
# Programmable Reload Countdown Timer

A 16-bit down-counter with a reload register and a periodic interrupt request. Software reaches it over a byte-wide register bus. It loads the reload value and the current count one byte at a time. It then sets the run and interrupt-enable bits in the control/status register. A fixed prescaler turns the system clock into decrement ticks. Each time the count steps down to zero, the timer raises a sticky interrupt flag. On the next tick it refills the count from the reload register, so the timer runs on without software help.

The flag stays set, and the request stays asserted, until software performs a two-step read. It first reads the control/status register while the flag is set, then reads the low byte of the count. Any other access leaves the flag alone, so a handler that skips this sequence is re-entered again and again. The block also presents a constant vector offset that a surrounding interrupt controller adds to its vector base.

Register addresses: 0 is count low, 1 is count high, 2 is reload low, 3 is reload high, and 4 is control/status. Any other address reads as zero.

Top module: `prt_timer`

## Requirements
- R1: After reset, the count and reload registers read 0xFFFF, the control/status register reads 0x00, and `irq` is low.
- R2: Writing addresses 0 to 3 sets one byte of the count or the reload, and a read of the same address returns that byte.
- R3: Control/status bit 0 is the run bit and bit 4 is the interrupt enable; both are written and read back there. Bit 6 is the read-only interrupt flag, and the other bits read as zero.
- R4: While running, the count decrements once every PRE_DIV (default 20) clocks. With count N at start, the flag appears 20·N clocks after the write that sets the run bit.
- R5: A tick that finds the count at zero reloads it from the reload register. Once running, interrupts therefore recur every 20·(N+1) clocks for reload value N.
- R6: The flag is cleared only when a read of address 0 follows a read of address 4 made while the flag was set. A read of address 0 alone leaves the flag set.
- R7: `irq` equals the flag ANDed with the interrupt enable. It stays high for as long as the flag is not cleared.
- R8: Clearing the run bit freezes the count at its current value, and setting it again resumes counting from that value.
- R9: `vec_ofs` always reads 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Register access strobe, one cycle per access |
| wr | input | 1 | Write when sel is high |
| rd | input | 1 | Read when sel is high; read side effects occur at the clock edge |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational on addr |
| irq | output | 1 | Interrupt request |
| vec_ofs | output | 8 | Fixed vector offset |

## Verification
The bound checker watches the following on every cycle:
- the prescaler stays within range;
- the count moves by at most one step per cycle while running;
- the count stays frozen while stopped;
- the flag rises only as the count reaches zero;
- the flag is held until a low-count read;
- the request is gated by the enable.

Only the bench scenarios can show the exact interrupt latency and period for chosen reload values. They also show that the two-step read is needed, because a lone low-byte read does not clear the flag. Byte readback and resumption after a stop are likewise shown only there.

// File: rtl/prt_timer.sv
module prt_timer #(
  parameter int PRE_DIV = 20,
  parameter logic [7:0] VEC_OFS = 8'h04
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       wr,
  input  logic       rd,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  output logic [7:0] vec_ofs
);
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [2:0] A_CLO = 3'd0, A_CHI = 3'd1, A_RLO = 3'd2, A_RHI = 3'd3, A_CSR = 3'd4;

  logic [15:0]   cnt, rld;
  logic [PW-1:0] pre;
  logic          run, ie, flag, armed;

  wire wr_en   = sel & wr;
  wire rd_en   = sel & rd;
  wire cnt_wr  = wr_en & (addr == A_CLO | addr == A_CHI);
  wire tick    = run & (pre == PW'(PRE_DIV - 1));
  wire f_set   = tick & ~cnt_wr & (cnt == 16'd1);
  wire f_clr   = rd_en & (addr == A_CLO) & armed;

  always_ff @(posedge clk) begin
    if (!rst_n)        pre <= '0;
    else if (!run || tick) pre <= '0;
    else               pre <= pre + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= 16'hFFFF;
    end else if (cnt_wr) begin
      if (addr == A_CLO) cnt[7:0]  <= wdata;
      else               cnt[15:8] <= wdata;
    end else if (tick) begin
      cnt <= (cnt == 16'd0) ? rld : cnt - 16'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rld <= 16'hFFFF;
      run <= 1'b0;
      ie  <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        A_RLO: rld[7:0]  <= wdata;
        A_RHI: rld[15:8] <= wdata;
        A_CSR: begin run <= wdata[0]; ie <= wdata[4]; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      flag <= f_set | (flag & ~f_clr);
      if (f_clr)                                   armed <= 1'b0;
      else if (rd_en && addr == A_CSR && flag)     armed <= 1'b1;
    end
  end

  always_comb begin
    case (addr)
      A_CLO:   rdata = cnt[7:0];
      A_CHI:   rdata = cnt[15:8];
      A_RLO:   rdata = rld[7:0];
      A_RHI:   rdata = rld[15:8];
      A_CSR:   rdata = {1'b0, flag, 1'b0, ie, 3'b000, run};
      default: rdata = 8'h00;
    endcase
  end

  assign irq     = flag & ie;
  assign vec_ofs = VEC_OFS;
endmodule

// File: rtl/prt_timer_chk.sv
module prt_timer_chk #(
  parameter int PRE_DIV = 20,
  parameter int PW = 5
) (
  input logic        clk,
  input logic        rst_n,
  input logic        sel,
  input logic        wr,
  input logic        rd,
  input logic [2:0]  addr,
  input logic [15:0] cnt,
  input logic [PW-1:0] pre,
  input logic        run,
  input logic        ie,
  input logic        flag,
  input logic        irq
);
  wire cw = sel & wr & (addr <= 3'd1);

  // R4
  pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n) 32'(pre) < PRE_DIV);

  // R4
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && !cw && cnt != 16'd0 |=> (cnt == $past(cnt) || cnt == $past(cnt) - 16'd1));

  // R8
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !cw |=> $stable(cnt));

  // R5
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> cnt == 16'd0);

  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !(sel && rd && addr == 3'd0) |=> flag);

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ie && flag));
endmodule

bind prt_timer prt_timer_chk #(.PRE_DIV(PRE_DIV), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .rd(rd), .addr(addr),
  .cnt(cnt), .pre(pre), .run(run), .ie(ie), .flag(flag), .irq(irq)
);

// File: tb/tb_prt_timer.sv
module tb_prt_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata, vec_ofs;
  logic       irq;
  int         checks = 0, errors = 0;
  int         cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  prt_timer dut (.clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .rd(rd), .addr(addr),
                 .wdata(wdata), .rdata(rdata), .irq(irq), .vec_ofs(vec_ofs));

  function automatic int first_lat(int n); return 20 * n; endfunction
  function automatic int period(int n);    return 20 * (n + 1); endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic bus_rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1; rd = 1; addr = a;
    #1 d = rdata;
    @(posedge clk);
    @(negedge clk); sel = 0; rd = 0;
  endtask

  task automatic wait_irq(output int t);
    int k = 0;
    while (!irq && k < 5000) begin @(negedge clk); k++; end
    t = cyc;
  endtask

  task automatic clear_flag();
    logic [7:0] d;
    bus_rd(3'd4, d);
    bus_rd(3'd0, d);
  endtask

  task automatic setup(int n, logic [7:0] ctl);
    bus_wr(3'd4, 8'h00);
    clear_flag();
    bus_wr(3'd2, n[7:0]);  bus_wr(3'd3, n[15:8]);
    bus_wr(3'd0, n[7:0]);  bus_wr(3'd1, n[15:8]);
    bus_wr(3'd4, ctl);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d, d2;
    int t0, t1, t2, v1, v2, n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    bus_rd(3'd0, d); chk("R1 cnt lo", d, 8'hFF);
    bus_rd(3'd1, d); chk("R1 cnt hi", d, 8'hFF);
    bus_rd(3'd3, d); chk("R1 rld hi", d, 8'hFF);
    bus_rd(3'd4, d); chk("R1 csr", d, 8'h00);
    chk("R1 irq", irq, 0);
    // R9
    chk("R9 vec", vec_ofs, 8'h04);

    // R2 byte readback
    bus_wr(3'd2, 8'h5A); bus_wr(3'd3, 8'hC3);
    bus_rd(3'd2, d); chk("R2 rld lo", d, 8'h5A);
    bus_rd(3'd3, d); chk("R2 rld hi", d, 8'hC3);
    bus_wr(3'd0, 8'h34); bus_wr(3'd1, 8'h12);
    bus_rd(3'd0, d); chk("R2 cnt lo", d, 8'h34);
    bus_rd(3'd1, d); chk("R2 cnt hi", d, 8'h12);
    bus_rd(3'd6, d); chk("R2 unmapped", d, 8'h00);

    // R3 control bits
    bus_wr(3'd4, 8'hFF); bus_rd(3'd4, d);
    chk("R3 csr bits", d & 8'hBF, 8'h11);
    bus_wr(3'd4, 8'h00);

    // R4 R5 R6 R7: directed then random periods
    for (int i = 0; i < 6; i++) begin
      n = (i == 0) ? 2 : 2 + $urandom_range(40, 0);
      setup(n, 8'h11);
      t0 = cyc;
      wait_irq(t1);
      chk("R4 first latency", t1 - t0, first_lat(n));
      if (i == 0) begin
        bus_rd(3'd0, d);
        repeat (10) @(negedge clk);
        chk("R6 lone low read keeps irq", irq, 1);
        chk("R7 irq held", irq, 1);
      end
      bus_rd(3'd4, d); chk("R3 flag bit6", d, 8'h51);
      bus_rd(3'd0, d);
      @(negedge clk);
      chk("R6 cleared", irq, 0);
      wait_irq(t2);
      chk("R5 period", t2 - t1, period(n));
    end

    // R7 enable gates irq
    setup(3, 8'h01);
    repeat (first_lat(3) + 5) @(negedge clk);
    chk("R7 irq gated", irq, 0);
    bus_rd(3'd4, d); chk("R7 flag visible", d, 8'h41);
    bus_rd(3'd0, d);
    bus_rd(3'd4, d); chk("R6 clear with ie off", d, 8'h01);

    // R8 freeze and resume
    setup(16'h0100, 8'h01);
    repeat (300) @(negedge clk);
    bus_wr(3'd4, 8'h00);
    bus_rd(3'd0, d); bus_rd(3'd1, d2); v1 = {d2, d};
    repeat (200) @(negedge clk);
    bus_rd(3'd0, d); bus_rd(3'd1, d2); v2 = {d2, d};
    chk("R8 frozen", v2, v1);
    bus_wr(3'd4, 8'h01);
    repeat (100) @(negedge clk);
    bus_wr(3'd4, 8'h00);
    bus_rd(3'd0, d); bus_rd(3'd1, d2); v2 = {d2, d};
    chk("R8 resumed", v1 - v2, 5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule